// File: doc/BRIEF.md
# Clip Record and Playback Transport

This block records a short audio clip into an external sample memory and plays it back under switch control. One address pointer drives the memory in both directions. During capture it walks upward and writes one ADC sample per sample-rate strobe. During playback it reads one sample per strobe and hands the value to the DAC path. A playback tick can move the pointer forward or backward, by one sample or by a faster stride, or it can leave the pointer where it is.

Recording begins on a rising edge of the record switch. It stops when the switch drops or when the memory is full, and the number of samples written becomes the clip length. Playback runs while the play switch is high. It starts at address 0 and never reads at or beyond the clip length. Pause, fast-forward and reverse each have their own switch, and a two-bit code picks the stride used by the fast modes. The memory sits outside the block and is read with one cycle of latency.

Top module: `clip_transport`

## Requirements
- R1: After a synchronous reset, mem_we, dac_sample, dac_valid, done, paused, rec_active, play_active and clip_len are all zero.
- R2: The pointer moves, and a memory write or read is issued, only in a cycle where smp_tick is high. Each tick in which it moves gives exactly one write pulse or one dac_valid pulse.
- R3: A rising edge of rec_sw while idle starts capture at address 0. Each tick writes adc_sample to the next address. clip_len equals the number of samples written. Capture ends when rec_sw falls or after CLIP_SAMPLES writes, and holding rec_sw high after that starts no new capture.
- R4: In normal play (no mode switch set), each tick reads the current address and moves the pointer up by 1. dac_sample takes the read value on the second clock edge after the read address is presented, and dac_valid pulses for one cycle at the same time.
- R5: With ffwd_sw set, each tick moves the pointer up by a stride selected by speed_sel: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8.
- R6: With rev_sw set, each tick moves the pointer down by the same stride. Reverse takes priority over fast-forward when both switches are set.
- R7: With pause_sw set during play, ticks issue no read and do not move the pointer. dac_sample holds its last value, dac_valid stays low, and paused reads 1. Pause takes priority over every other mode.
- R8: A forward step that would reach or pass clip_len-1 lands on clip_len-1. A backward step that would reach or pass 0 lands on 0. Both set done. A step that stops short of the end clears done.
- R9: Playback never reads an address at or above clip_len, including after a short recording. With clip_len 0, play_sw has no effect.
- R10: While playing, rec_sw is ignored and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle sample-rate strobe |
| rec_sw | input | 1 | Record switch (rising edge starts capture) |
| play_sw | input | 1 | Play switch (level) |
| pause_sw | input | 1 | Pause switch |
| ffwd_sw | input | 1 | Fast-forward switch |
| rev_sw | input | 1 | Reverse switch |
| speed_sel | input | 2 | Stride code for the fast modes |
| adc_sample | input | SMP_W | Sample from the ADC path |
| mem_addr | output | ADDR_W | Sample memory address |
| mem_we | output | 1 | Sample memory write enable |
| mem_wdata | output | SMP_W | Sample memory write data |
| mem_rdata | input | SMP_W | Sample memory read data, one cycle after the address |
| dac_sample | output | SMP_W | Sample toward the DAC path |
| dac_valid | output | 1 | Pulses when dac_sample is updated |
| rec_active | output | 1 | Capture in progress |
| play_active | output | 1 | Playback in progress |
| paused | output | 1 | Playback paused |
| done | output | 1 | Pointer clamped at a clip boundary |
| clip_len | output | ADDR_W+1 | Number of recorded samples |

## Verification
In one tick the stride step and the end-of-clip clamp can happen together: an 8-sample or 4-sample move taken from a position that is not aligned to the stride overshoots the clip's last sample or address 0. The bench provokes this with directed runs at the largest stride and with random mixes of direction, speed and pause over both a full and a very short clip. It judges the result from the sample that reaches the DAC on the following tick and from the done flag, against its own model of the clamped pointer. Ticks that arrive while several mode switches are set at once test the pause-over-reverse-over-forward priority in the same way.

// File: rtl/clip_pkg.sv
package clip_pkg;
  localparam int STEP_W = 4;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REC  = 2'd1,
    XS_PLAY = 2'd2
  } xport_state_t;

  // stride code: 0 -> 1, 1 -> 4, 2/3 -> 8
  function automatic logic [STEP_W-1:0] speed_to_step(input logic [1:0] sel);
    case (sel)
      2'b00:   speed_to_step = STEP_W'(1);
      2'b01:   speed_to_step = STEP_W'(4);
      default: speed_to_step = STEP_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/xport_step.sv
module xport_step #(
  parameter int ADDR_W = 19,
  parameter int STEP_W = 4
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W:0]   len,
  input  logic [STEP_W-1:0] step,
  input  logic              backward,
  output logic [ADDR_W-1:0] nxt,
  output logic              at_edge
);
  logic [ADDR_W:0] cur_w;
  logic [ADDR_W:0] step_w;
  logic [ADDR_W:0] sum_w;
  logic [ADDR_W:0] last_w;

  always_comb begin
    cur_w  = {1'b0, cur};
    step_w = {{(ADDR_W+1-STEP_W){1'b0}}, step};
    sum_w  = cur_w + step_w;
    last_w = (len == '0) ? '0 : len - {{ADDR_W{1'b0}}, 1'b1};
    if (backward) begin
      if (cur_w <= step_w) begin
        nxt     = '0;
        at_edge = 1'b1;
      end else begin
        nxt     = cur - step_w[ADDR_W-1:0];
        at_edge = 1'b0;
      end
    end else begin
      if (sum_w >= last_w) begin
        nxt     = last_w[ADDR_W-1:0];
        at_edge = 1'b1;
      end else begin
        nxt     = sum_w[ADDR_W-1:0];
        at_edge = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xport_dac.sv
module xport_dac #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_go,
  input  logic [SMP_W-1:0] mem_rdata,
  output logic [SMP_W-1:0] dac_sample,
  output logic             dac_valid
);
  logic rd_land;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_land    <= 1'b0;
      dac_sample <= '0;
      dac_valid  <= 1'b0;
    end else begin
      rd_land   <= rd_go;
      dac_valid <= rd_land;
      if (rd_land) dac_sample <= mem_rdata;
    end
  end

  // R4: a presented read reaches the DAC two edges later
  p_read_lands_r4: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> ##2 dac_valid);

  // R2: no DAC update without a read two edges before
  p_valid_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_valid) |-> $past(rd_go, 2));
endmodule

// File: rtl/clip_transport.sv
module clip_transport
  import clip_pkg::*;
#(
  parameter int SMP_W        = 16,
  parameter int CLIP_SAMPLES = 480000,
  parameter int ADDR_W       = $clog2(CLIP_SAMPLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_tick,
  input  logic              rec_sw,
  input  logic              play_sw,
  input  logic              pause_sw,
  input  logic              ffwd_sw,
  input  logic              rev_sw,
  input  logic [1:0]        speed_sel,
  input  logic [SMP_W-1:0]  adc_sample,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [SMP_W-1:0]  mem_wdata,
  input  logic [SMP_W-1:0]  mem_rdata,
  output logic [SMP_W-1:0]  dac_sample,
  output logic              dac_valid,
  output logic              rec_active,
  output logic              play_active,
  output logic              paused,
  output logic              done,
  output logic [ADDR_W:0]   clip_len
);
  localparam logic [ADDR_W:0] CLIP_LEN = (ADDR_W+1)'(CLIP_SAMPLES);

  xport_state_t      st;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W:0]   len_q;
  logic [ADDR_W:0]   wr_count;
  logic              rec_q;
  logic              rd_go;
  logic              paused_q;
  logic              done_q;
  logic              rec_start;
  logic [STEP_W-1:0] step_sz;
  logic [ADDR_W-1:0] step_nxt;
  logic              step_edge;

  assign rec_start = rec_sw && !rec_q && (st == XS_IDLE);
  assign step_sz   = (rev_sw || ffwd_sw) ? speed_to_step(speed_sel) : STEP_W'(1);
  assign wr_count  = {1'b0, ptr} + {{ADDR_W{1'b0}}, 1'b1};

  xport_step #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_step (
    .cur     (ptr),
    .len     (len_q),
    .step    (step_sz),
    .backward(rev_sw),
    .nxt     (step_nxt),
    .at_edge (step_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= XS_IDLE;
      ptr       <= '0;
      len_q     <= '0;
      rec_q     <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      rd_go     <= 1'b0;
      paused_q  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rec_q    <= rec_sw;
      mem_we   <= 1'b0;
      rd_go    <= 1'b0;
      paused_q <= (st == XS_PLAY) && play_sw && pause_sw;
      unique case (st)
        XS_IDLE: begin
          if (rec_start) begin
            st     <= XS_REC;
            ptr    <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
          end else if (play_sw && (len_q != '0)) begin
            st     <= XS_PLAY;
            ptr    <= '0;
            done_q <= 1'b0;
          end
        end
        XS_REC: begin
          if (!rec_sw) begin
            st <= XS_IDLE;
          end else if (smp_tick) begin
            mem_addr  <= ptr;
            mem_wdata <= adc_sample;
            mem_we    <= 1'b1;
            len_q     <= wr_count;
            ptr       <= wr_count[ADDR_W-1:0];
            if (wr_count == CLIP_LEN) st <= XS_IDLE;
          end
        end
        XS_PLAY: begin
          if (!play_sw) begin
            st <= XS_IDLE;
          end else if (smp_tick && !pause_sw) begin
            mem_addr <= ptr;
            rd_go    <= 1'b1;
            ptr      <= step_nxt;
            done_q   <= step_edge;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  xport_dac #(.SMP_W(SMP_W)) u_dac (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .mem_rdata (mem_rdata),
    .dac_sample(dac_sample),
    .dac_valid (dac_valid)
  );

  assign rec_active  = (st == XS_REC);
  assign play_active = (st == XS_PLAY);
  assign paused      = paused_q;
  assign done        = done_q;
  assign clip_len    = len_q;

  // R3 / R2: a write follows a capture tick only
  p_we_from_rec_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past((st == XS_REC) && smp_tick && rec_sw));

  // R10: no write while playing
  p_no_write_in_play_r10: assert property (@(posedge clk) disable iff (rst)
    (st == XS_PLAY) |=> !mem_we);

  // R9: reads stay inside the recorded clip
  p_read_in_clip_r9: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> ({1'b0, mem_addr} < len_q));

  // R7: a sustained pause produces no DAC update
  p_pause_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (paused_q && $past(paused_q) && $past(paused_q, 2)) |-> !dac_valid);

  // R5: an unclamped forward tick moves by the selected stride
  p_fwd_stride_r5: assert property (@(posedge clk) disable iff (rst)
    ((st == XS_PLAY) && play_sw && smp_tick && !pause_sw && !rev_sw && !step_edge)
      |=> (ptr == $past(ptr) + {{(ADDR_W-STEP_W){1'b0}}, $past(step_sz)}));

  // R8: done only at a clip boundary
  p_done_at_edge_r8: assert property (@(posedge clk) disable iff (rst)
    ((st == XS_PLAY) && done_q) |-> ((ptr == '0) || ({1'b0, ptr} == len_q - {{ADDR_W{1'b0}}, 1'b1})));
endmodule

// File: tb/clip_transport_tb.sv
module clip_transport_tb;
  localparam int SMP_W  = 16;
  localparam int CLIP   = 64;
  localparam int ADDR_W = $clog2(CLIP);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_tick = 1'b0;
  logic              rec_sw = 1'b0, play_sw = 1'b0, pause_sw = 1'b0, ffwd_sw = 1'b0, rev_sw = 1'b0;
  logic [1:0]        speed_sel = 2'b00;
  logic [SMP_W-1:0]  adc_sample = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [SMP_W-1:0]  mem_wdata;
  logic [SMP_W-1:0]  mem_rdata;
  logic [SMP_W-1:0]  dac_sample;
  logic              dac_valid, rec_active, play_active, paused, done;
  logic [ADDR_W:0]   clip_len;

  always #4 clk = ~clk;

  clip_transport #(.SMP_W(SMP_W), .CLIP_SAMPLES(CLIP)) u_dut (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .rec_sw(rec_sw), .play_sw(play_sw),
    .pause_sw(pause_sw), .ffwd_sw(ffwd_sw), .rev_sw(rev_sw), .speed_sel(speed_sel),
    .adc_sample(adc_sample), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dac_sample(dac_sample), .dac_valid(dac_valid),
    .rec_active(rec_active), .play_active(play_active), .paused(paused), .done(done),
    .clip_len(clip_len)
  );

  logic [SMP_W-1:0] ram [CLIP];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int we_cnt = 0, val_cnt = 0;
  always @(posedge clk) begin
    if (!rst && mem_we) we_cnt <= we_cnt + 1;
    if (!rst && dac_valid) val_cnt <= val_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  logic [SMP_W-1:0] exp_mem [CLIP];
  int m_len = 0, m_ptr = 0, m_done = 0;
  logic [SMP_W-1:0] m_dac = '0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stride(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 8;
  endfunction

  task automatic record(input int n);
    int w0;
    w0 = we_cnt;
    @(negedge clk) rec_sw = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 rec_active", rec_active, 1);
    for (int i = 0; i < n; i++) begin
      adc_sample = SMP_W'($urandom);
      if (i < CLIP) exp_mem[i] = adc_sample;
      smp_tick = 1'b1;
      @(negedge clk) smp_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
    m_len = (n < CLIP) ? n : CLIP;
    chk("R3 rec stops at capacity", rec_active, (n >= CLIP) ? 0 : 1);
    rec_sw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 clip_len", clip_len, m_len);
    chk("R2 one write per tick", we_cnt - w0, m_len);
    chk("R3 rec_active off", rec_active, 0);
    for (int i = 0; i < m_len; i += 7)
      chk("R3 stored sample", ram[i], exp_mem[i]);
  endtask

  task automatic start_play();
    @(negedge clk) play_sw = 1'b1;
    repeat (2) @(negedge clk);
    m_ptr = 0;
    m_done = 0;
    chk("R9 play starts with clip", play_active, 1);
  endtask

  task automatic stop_play();
    @(negedge clk) begin
      play_sw = 1'b0; rec_sw = 1'b0; pause_sw = 1'b0; ffwd_sw = 1'b0; rev_sw = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic ptick(input logic pz, input logic ff, input logic rv, input logic [1:0] sp, input logic rc);
    int w0, v0, stp;
    string tag;
    pause_sw = pz; ffwd_sw = ff; rev_sw = rv; speed_sel = sp; rec_sw = rc;
    w0 = we_cnt; v0 = val_cnt;
    @(negedge clk) smp_tick = 1'b1;
    @(negedge clk) smp_tick = 1'b0;
    repeat (3) @(negedge clk);
    tag = pz ? "R7 pause" : rv ? "R6 reverse" : ff ? "R5 ffwd" : "R4 play";
    if (!pz) begin
      m_dac = exp_mem[m_ptr];
      stp = (rv || ff) ? stride(sp) : 1;
      if (rv) begin
        if (m_ptr <= stp) begin m_ptr = 0; m_done = 1; end
        else begin m_ptr -= stp; m_done = 0; end
      end else begin
        if (m_ptr + stp >= m_len - 1) begin m_ptr = m_len - 1; m_done = 1; end
        else begin m_ptr += stp; m_done = 0; end
      end
    end
    chk(tag, dac_sample, m_dac);
    chk("R8 done", done, m_done);
    chk("R7 paused flag", paused, pz);
    chk("R2 one read per tick", val_cnt - v0, pz ? 0 : 1);
    chk("R10 no write in play", we_cnt - w0, 0);
    chk("R9 address in clip", (int'(mem_addr) < m_len) ? 1 : 0, 1);
  endtask

  task automatic random_play(input int n);
    for (int i = 0; i < n; i++) begin
      logic pz, ff, rv, rc;
      logic [1:0] sp;
      pz = ($urandom % 5) == 0;
      ff = ($urandom % 2) == 1;
      rv = ($urandom % 3) == 0;
      sp = 2'($urandom);
      rc = ($urandom % 4) == 0;
      ptick(pz, ff, rv, sp, rc);
    end
  endtask

  initial begin
    bit hung;
    hung = 1'b0;
    fork
      begin
        repeat (150000) @(posedge clk);
        hung = 1'b1;
      end
      begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 mem_we", mem_we, 0);
        chk("R1 dac_sample", dac_sample, 0);
        chk("R1 dac_valid", dac_valid, 0);
        chk("R1 done", done, 0);
        chk("R1 clip_len", clip_len, 0);
        chk("R1 rec/play", {rec_active, play_active, paused}, 0);

        // R9: empty clip ignores play
        @(negedge clk) play_sw = 1'b1;
        repeat (2) @(negedge clk);
        smp_tick = 1'b1;
        @(negedge clk) smp_tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 no play on empty clip", play_active, 0);
        chk("R9 no read on empty clip", val_cnt, 0);
        play_sw = 1'b0;
        repeat (2) @(negedge clk);

        // short clip, plain play to the end
        record(20);
        start_play();
        for (int i = 0; i < 24; i++) ptick(0, 0, 0, 2'b00, 0);
        chk("R8 done at last sample", done, 1);
        stop_play();
        start_play();
        random_play(200);
        stop_play();

        // full clip; record switch held past capacity
        record(CLIP + 6);
        start_play();
        // directed: 8x forward from unaligned position overshoots the end
        ptick(0, 1, 0, 2'b00, 0);
        for (int i = 0; i < 9; i++) ptick(0, 1, 0, 2'b10, 0);
        chk("R8 forward clamp", done, 1);
        // reverse beats ffwd, 4x down to 0
        for (int i = 0; i < 18; i++) ptick(0, 1, 1, 2'b01, 0);
        chk("R6 reverse clamp", done, 1);
        // pause beats reverse and ffwd
        ptick(1, 1, 1, 2'b10, 1);
        ptick(0, 0, 0, 2'b00, 1);
        chk("R8 done cleared by free step", done, 0);
        random_play(200);
        stop_play();

        // single-sample clip
        record(1);
        start_play();
        ptick(0, 0, 0, 2'b00, 0);
        ptick(0, 0, 1, 2'b10, 0);
        random_play(30);
        stop_play();
      end
    join_any
    if (hung) begin
      n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule